// File: doc/BRIEF.md
# Byte Permute Unit with Sign Replication

This unit builds a 32-bit result one byte at a time from a pool of eight source bytes made up of two 32-bit operands. A 16-bit selector holds one 4-bit code per result byte. The low three bits of a code name one byte of the pool. The top bit of the code decides what happens to that byte. Either the byte is copied unchanged, or the result byte is filled with copies of that byte's most significant bit.

Copy codes are used to extract, insert and reorder bytes, and to shift by whole bytes. Fill codes turn a per-byte sign or flag bit into a 0x00/0xFF byte mask, which is handy for byte-wise saturation and select tricks inside a 32-bit word. In the default registered form the unit adds one cycle of latency. A valid strobe travels alongside the data, and the result register loads only on valid input.

Top module: `bperm_unit`

## Requirements
- R1: The pool byte index runs 0 to 7. Bytes 0 to 3 are `opa[7:0]`, `opa[15:8]`, `opa[23:16]` and `opa[31:24]`. Bytes 4 to 7 are the same slices of `opb`.
- R2: The code for result byte k (bits 8k+7:8k) is `sel[4k+3:4k]`, and it has no effect on any other result byte.
- R3: A code whose bit 3 is 0 makes the result byte an exact copy of the pool byte indexed by code bits 2:0.
- R4: A code whose bit 3 is 1 sets all eight bits of the result byte to bit 7 of the pool byte indexed by code bits 2:0.
- R5: When `opb` is zero and `sel` is 0xBA98, each result byte is 0xFF if the matching byte of `opa` has bit 7 set, and 0x00 otherwise.
- R6: The result for inputs presented with `in_valid` high appears on `result` one clock later, and `out_valid` equals `in_valid` delayed by one clock.
- R7: While `in_valid` is low, `result` keeps its previous value whatever `opa`, `opb` and `sel` do.
- R8: A synchronous active-low reset clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| opa | input | 32 | Operand supplying pool bytes 0 to 3 |
| opb | input | 32 | Operand supplying pool bytes 4 to 7 |
| sel | input | 16 | Four 4-bit lane codes |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Permuted result |

## Verification
The unit holds almost no state. A fault shows up on the very next clock as a wrong byte on `result`. That byte may come from the wrong pool slot, be copied where it should be filled, be filled from the wrong bit, or be steered to a neighbouring lane. Each lane code is swept through all sixteen values while the other lanes stay fixed, so a lane picking the wrong byte or leaking into its neighbours is exposed within a single transfer. A register that loads while `in_valid` is low, or a valid strobe off by a cycle, shows within one idle cycle.

// File: rtl/bperm_pkg.sv
// Package: shared sizing helpers for the byte permute unit.
// Assumes a pool of twice as many bytes as there are result lanes.
package bperm_pkg;

    // Index width needed to address a pool of 2*lanes bytes.
    function automatic int idx_width(input int lanes);
        return $clog2(2 * lanes);
    endfunction

    // Per-lane code width: pool index plus the fill/copy mode bit.
    function automatic int code_width(input int lanes);
        return $clog2(2 * lanes) + 1;
    endfunction

    // Lane operating mode taken from the top bit of a lane code.
    typedef enum logic {
        LANE_COPY = 1'b0,
        LANE_FILL = 1'b1
    } lane_mode_e;

endpackage

// File: rtl/bperm_pool.sv
// Module: bperm_pool
// Joins the two operands into one flat byte pool, with operand A in
// the low bytes and operand B in the high bytes.
// Assumes both operands are LANES bytes wide.
module bperm_pool #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int OP_W  = LANES * BYTE_W
) (
    input  logic [OP_W-1:0]   op_lo,
    input  logic [OP_W-1:0]   op_hi,
    output logic [2*OP_W-1:0] pool
);

    // Place the low operand in bytes 0..LANES-1 and the high one above it.
    always_comb begin
        pool = {op_hi, op_lo};
    end

endmodule

// File: rtl/bperm_lane.sv
// Module: bperm_lane
// Produces one result byte. It picks a pool byte by index, then either
// passes it through or fills the lane with that byte's top bit.
// Assumes the pool size is a power of two that matches IDX_W.
module bperm_lane
    import bperm_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int BYTE_W  = 8,
    localparam int POOL_N = 2 * LANES,
    localparam int IDX_W  = idx_width(LANES),
    localparam int CODE_W = code_width(LANES)
) (
    input  logic [POOL_N*BYTE_W-1:0] pool,
    input  logic [CODE_W-1:0]        code,
    output logic [BYTE_W-1:0]        lane_out
);

    logic [IDX_W-1:0]  pick_idx;
    lane_mode_e        mode;
    logic [BYTE_W-1:0] picked;
    logic              top_bit;

    // Split the lane code into a pool index and a mode.
    always_comb begin
        pick_idx = code[IDX_W-1:0];
        mode     = lane_mode_e'(code[CODE_W-1]);
    end

    // Select the addressed pool byte and take its most significant bit.
    always_comb begin
        picked  = pool[pick_idx*BYTE_W +: BYTE_W];
        top_bit = picked[BYTE_W-1];
    end

    // Pass the byte through or replicate its top bit, depending on mode.
    always_comb begin
        unique case (mode)
            LANE_FILL: lane_out = {BYTE_W{top_bit}};
            default:   lane_out = picked;
        endcase
    end

endmodule

// File: rtl/bperm_core.sv
// Module: bperm_core
// Combinational permute datapath: builds the pool and runs one lane
// per result byte. Lane k reads code field k of the selector.
// Assumes the selector packs LANES codes with the lowest field first.
module bperm_core
    import bperm_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int BYTE_W  = 8,
    localparam int OP_W   = LANES * BYTE_W,
    localparam int CODE_W = code_width(LANES),
    localparam int SEL_W  = LANES * CODE_W
) (
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [SEL_W-1:0] sel,
    output logic [OP_W-1:0]  perm
);

    logic [2*OP_W-1:0] pool;

    bperm_pool #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_pool (
        .op_lo (op_a),
        .op_hi (op_b),
        .pool  (pool)
    );

    // One lane per result byte, each driven by its own code field.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bperm_lane #(
            .LANES  (LANES),
            .BYTE_W (BYTE_W)
        ) u_lane (
            .pool     (pool),
            .code     (sel[k*CODE_W +: CODE_W]),
            .lane_out (perm[k*BYTE_W +: BYTE_W])
        );
    end

endmodule

// File: rtl/bperm_unit.sv
// Module: bperm_unit (top)
// Byte permute unit with a per-lane copy or sign-fill choice.
// REGISTERED=1 gives one cycle of latency: the result register loads
// only when in_valid is high, and out_valid is in_valid delayed by one
// clock. REGISTERED=0 gives a purely combinational path in which
// out_valid follows in_valid directly.
// Assumes a synchronous active-low reset.
module bperm_unit
    import bperm_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int BYTE_W     = 8,
    parameter bit REGISTERED = 1'b1,
    localparam int OP_W      = LANES * BYTE_W,
    localparam int CODE_W    = code_width(LANES),
    localparam int SEL_W     = LANES * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  opa,
    input  logic [OP_W-1:0]  opb,
    input  logic [SEL_W-1:0] sel,
    output logic             out_valid,
    output logic [OP_W-1:0]  result
);

    logic [OP_W-1:0] perm_c;

    bperm_core #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_core (
        .op_a (opa),
        .op_b (opb),
        .sel  (sel),
        .perm (perm_c)
    );

    if (REGISTERED) begin : g_reg
        logic            vld_q;
        logic [OP_W-1:0] res_q;

        // Delay the valid strobe by one stage.
        always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= in_valid;
        end

        // Capture the permuted word only on a valid input.
        always_ff @(posedge clk) begin
            if (!rst_n)        res_q <= '0;
            else if (in_valid) res_q <= perm_c;
        end

        // Drive the outputs from the stage registers.
        always_comb begin
            out_valid = vld_q;
            result    = res_q;
        end
    end else begin : g_comb
        // Pass the datapath straight through.
        always_comb begin
            out_valid = in_valid;
            result    = perm_c;
        end
    end

endmodule

// File: rtl/bperm_unit_chk.sv
// Module: bperm_unit_chk
// Property checker for the registered form of bperm_unit. It holds a
// copy of the last accepted inputs and checks every result lane against
// them one cycle later.
module bperm_unit_chk
    import bperm_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int BYTE_W     = 8,
    parameter bit REGISTERED = 1'b1,
    localparam int OP_W      = LANES * BYTE_W,
    localparam int IDX_W     = idx_width(LANES),
    localparam int CODE_W    = code_width(LANES),
    localparam int SEL_W     = LANES * CODE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  opa,
    input logic [OP_W-1:0]  opb,
    input logic [SEL_W-1:0] sel,
    input logic             out_valid,
    input logic [OP_W-1:0]  result
);

    if (REGISTERED) begin : g_chk
        logic [2*OP_W-1:0] m_pool;
        logic [SEL_W-1:0]  m_sel;
        logic              m_vld;

        // Record the accepted inputs for the next cycle's lane checks.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_pool <= '0;
                m_sel  <= '0;
                m_vld  <= 1'b0;
            end else begin
                m_vld <= in_valid;
                if (in_valid) begin
                    m_pool <= {opb, opa};
                    m_sel  <= sel;
                end
            end
        end

        AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R6
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(result) && !out_valid)); // R7

        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [CODE_W-1:0] code;
            logic [BYTE_W-1:0] src;
            assign code = m_sel[k*CODE_W +: CODE_W];
            assign src  = m_pool[code[IDX_W-1:0]*BYTE_W +: BYTE_W];

            AST_LANE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
                (m_vld && !code[CODE_W-1]) |-> (result[k*BYTE_W +: BYTE_W] == src)); // R3
            AST_LANE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
                (m_vld && code[CODE_W-1]) |-> (result[k*BYTE_W +: BYTE_W] == {BYTE_W{src[BYTE_W-1]}})); // R4
        end
    end

endmodule

bind bperm_unit bperm_unit_chk #(
    .LANES      (LANES),
    .BYTE_W     (BYTE_W),
    .REGISTERED (REGISTERED)
) u_chk (.*);

// File: tb/bperm_unit_tb.sv
// Testbench for bperm_unit: directed corner cases, an exhaustive sweep
// of every code value on every lane, and seeded random traffic, all
// checked against a bench reference function.
module bperm_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic [15:0] sel = '0;
    logic        out_valid;
    logic [31:0] result;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bperm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opa(opa), .opb(opb), .sel(sel),
        .out_valid(out_valid), .result(result)
    );

    // Reference model written from R1 to R4.
    function automatic logic [31:0] ref_perm(input logic [31:0] a, input logic [31:0] b,
                                             input logic [15:0] s);
        logic [63:0] pool;
        logic [31:0] r;
        pool = {b, a};
        for (int k = 0; k < 4; k++) begin
            logic [3:0] c;
            logic [7:0] byt;
            c = s[4*k +: 4];
            byt = pool[c[2:0]*8 +: 8];
            r[8*k +: 8] = c[3] ? {8{byt[7]}} : byt;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one transfer at a falling edge, then check at the next falling edge.
    task automatic xfer(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] s);
        opa = a; opb = b; sel = s; in_valid = 1'b1;
        @(negedge clk);
        check(tag, result, ref_perm(a, b, s));
        check({tag, " R6 valid"}, {31'd0, out_valid}, 32'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] held;
        logic [31:0] ea, eb;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        // R8: the reset state.
        check("R8 result", result, 32'h0);
        check("R8 valid", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;

        // R1: identity picks operand A, codes 7..4 pick operand B.
        xfer("R1 A identity", 32'h44332211, 32'h88776655, 16'h3210);
        check("R1 A value", result, 32'h44332211);
        xfer("R1 B bytes", 32'h44332211, 32'h88776655, 16'h7654);
        check("R1 B value", result, 32'h88776655);
        // R3: reverse bytes and shift by one byte across operands.
        xfer("R3 reverse", 32'hA1B2C3D4, 32'h0, 16'h0123);
        check("R3 reverse value", result, 32'hD4C3B2A1);
        xfer("R3 shift", 32'hA1B2C3D4, 32'h11223344, 16'h4321);
        check("R3 shift value", result, 32'h44A1B2C3);
        // R5: sign to byte-mask idiom.
        xfer("R5 mask", 32'h12EF70A0, 32'h0, 16'hBA98);
        check("R5 mask value", result, 32'h00FF00FF);
        xfer("R5 mask all", 32'h80FF7F01, 32'h0, 16'hBA98);
        check("R5 mask all value", result, 32'hFFFF0000);
        // R4: fill from B bytes.
        xfer("R4 fill B", 32'h0, 32'h7F80017F, 16'hFEDC);
        check("R4 fill B value", result, 32'h00FF0000);

        // R2: sweep each lane through all 16 codes, others fixed at identity.
        ea = 32'hF1628314; eb = 32'h9506E728;
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 16; c++) begin
                logic [15:0] s;
                s = 16'h3210;
                s[4*k +: 4] = c[3:0];
                xfer(c[3] ? "R2 R4 sweep" : "R2 R3 sweep", ea, eb, s);
            end
        end

        // R7: inputs change while in_valid is low, result must hold.
        xfer("R7 load", 32'hCAFEF00D, 32'h0BADBEEF, 16'hC5A3);
        held = result;
        in_valid = 1'b0;
        opa = 32'h12345678; opb = 32'h9ABCDEF0; sel = 16'h7777;
        @(negedge clk);
        check("R7 hold", result, held);
        check("R6 valid low", {31'd0, out_valid}, 32'd0);
        opa = 32'hFFFFFFFF; sel = 16'hFFFF;
        @(negedge clk);
        check("R7 hold again", result, held);

        // R3 R4: seeded random traffic.
        for (int i = 0; i < 400; i++) begin
            xfer("R3 R4 random", $urandom, $urandom, 16'($urandom));
        end

        // R8: reset in mid-stream clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 re-reset result", result, 32'h0);
        check("R8 re-reset valid", {31'd0, out_valid}, 32'd0);
        finish_run();
    end

endmodule